// File: doc/BRIEF.md
# Register-Mapped SPI Master Port

This block is a byte-wide SPI master that software drives through three registers on a simple synchronous bus. One register holds status and control, one holds configuration, and one is the data buffer. When the data buffer is written while the port is idle, the port runs one full-duplex exchange of `DATA_W` bits. It shifts the written byte out on MOSI and, at the same time, shifts a byte in from MISO. When the exchange ends, the received byte can be read from the data buffer, and a sticky completion flag stays set until software clears it.

The configuration register selects the clock idle level, the sampling phase, the bit order and an exponent for the clock divider. Chip select is not part of this port; the surrounding logic drives it as a plain output. Register writes take effect at the rising clock edge where `regWrEn` is high. Reads are combinational from `regAddr`.

Top module: `spi_host_port`

## Requirements
- R1: After reset, the status, configuration and data registers all read 0, SCK is low and MOSI is low.
- R2: A write to the data register (address 2) while the port is idle starts an exchange. Status bit 0 (busy) reads 1 from the cycle after that write edge for exactly 16·H clocks, where H is the half-period.
- R3: While idle, SCK sits at configuration bit 7 (0 means low). During an exchange SCK toggles exactly 16 times, once every H clocks. H is 2^(E−16) for E = configuration bits 4:0 above 16, and 1 otherwise.
- R4: With configuration bit 6 = 0, the first data bit is on MOSI before the first SCK edge, MISO is sampled on the leading (odd-numbered, 1st, 3rd, …) edges, and MOSI changes on the trailing edges. With bit 6 = 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: Configuration bit 5 = 1 sends and receives the most significant bit first; bit 5 = 0 sends and receives the least significant bit first.
- R6: After an exchange, a read of the data register returns the byte received on MISO during that exchange.
- R7: Status bit 1 (done) is set when an exchange ends. It stays set until a status-register write (address 0) with bit 1 = 0. A status write with bit 1 = 1 leaves it set.
- R8: A data-register write while busy is ignored: the running exchange keeps its length, its MOSI bit stream and its received byte.
- R9: Status bits 7 and 5 always read 0 and ignore writes, so the port is always an SPI master.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select: 0 status, 1 configuration, 2 data |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational from regAddr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bound checker checks on every cycle that:
- busy only rises after a data write;
- SCK rests at the programmed idle level and makes exactly 16 toggles per exchange;
- the done flag rises only as busy falls and holds until a clearing write;
- the fixed status bits read 0.

The bench's scenarios are needed for the parts a property cannot see. A behavioural model of the SCK timeline and the busy window is compared every clock. A bench-side slave checks the MOSI bit stream and feeds MISO in each mode and bit order. The bench also checks that the received byte reads back correctly, that a data write during an exchange changes nothing, and that the divider gives the right half-period for exponents below, at and above the offset.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int REG_W = 8;
  localparam int EXP_W = 5;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_CONFIG = 2'd1;
  localparam logic [1:0] ADDR_DATA   = 2'd2;

  // configuration bit positions
  localparam int CFG_CPOL  = 7;
  localparam int CFG_CPHA  = 6;
  localparam int CFG_MSB   = 5;

  // status bit positions
  localparam int STAT_DONE = 1;
  localparam int STAT_BUSY = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // new exchange: take write data and bit order
    logic launch;   // advance the outgoing shift register
    logic capture;  // shift in the current MISO bit
    logic finish;   // last edge: latch the received word
  } dpStrobe_t;

endpackage

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EXP_OFFSET = 16,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] regRdData,
  output dpStrobe_t         strobe,
  output logic              orderMsb,
  output logic              sckOut,
  output logic              busy,
  output logic              doneFlag,
  output logic              idleCpol
);

  localparam int EDGE_CNT = 2 * DATA_W;
  localparam int EDGE_W   = $clog2(EDGE_CNT);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGE_CNT - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [REG_W-1:0]  cfgReg;
  logic [CNT_W-1:0]  halfCnt;
  logic [CNT_W-1:0]  limitM1;
  logic [EDGE_W-1:0] edgeIdx;
  logic              phaseBit;
  logic              actCpha;
  logic              actCpol;

  logic startXfer, cfgWr, statWr, tick, leading, lastEdge;

  // half-period minus one for a given exponent, saturating at both ends
  function automatic logic [CNT_W-1:0] limitFor(input logic [EXP_W-1:0] e);
    int sh;
    sh = int'(e) - EXP_OFFSET;
    if (sh < 0) sh = 0;
    if (sh > CNT_W - 1) sh = CNT_W - 1;
    return (CNT_ONE << sh) - CNT_ONE;
  endfunction

  always_comb begin
    startXfer = regWrEn && (regAddr == ADDR_DATA) && !busy;
    cfgWr     = regWrEn && (regAddr == ADDR_CONFIG);
    statWr    = regWrEn && (regAddr == ADDR_STATUS);
    tick      = busy && (halfCnt == limitM1);
    leading   = ~edgeIdx[0];
    lastEdge  = (edgeIdx == LAST_EDGE);
  end

  always_comb begin
    strobe.load    = startXfer;
    strobe.capture = tick && (actCpha ? !leading : leading);
    strobe.launch  = tick && (actCpha ? (leading && (edgeIdx != '0))
                                      : (!leading && !lastEdge));
    strobe.finish  = tick && lastEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      busy     <= 1'b0;
      doneFlag <= 1'b0;
      halfCnt  <= '0;
      limitM1  <= '0;
      edgeIdx  <= '0;
      phaseBit <= 1'b0;
      actCpha  <= 1'b0;
      actCpol  <= 1'b0;
    end else begin
      if (startXfer) begin
        busy     <= 1'b1;
        actCpha  <= cfgReg[CFG_CPHA];
        actCpol  <= cfgReg[CFG_CPOL];
        limitM1  <= limitFor(cfgReg[EXP_W-1:0]);
        halfCnt  <= '0;
        edgeIdx  <= '0;
        phaseBit <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          halfCnt  <= '0;
          phaseBit <= ~phaseBit;
          edgeIdx  <= edgeIdx + 1'b1;
          if (lastEdge) busy <= 1'b0;
        end else begin
          halfCnt <= halfCnt + CNT_ONE;
        end
      end

      if (cfgWr) cfgReg <= regWrData[REG_W-1:0];

      if (strobe.finish)                        doneFlag <= 1'b1;
      else if (statWr && !regWrData[STAT_DONE]) doneFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_STATUS: begin
        regRdData[STAT_DONE] = doneFlag;
        regRdData[STAT_BUSY] = busy;
      end
      ADDR_CONFIG: regRdData[REG_W-1:0] = cfgReg;
      ADDR_DATA:   regRdData = rxByte;
      default:     regRdData = '0;
    endcase
  end

  assign orderMsb = cfgReg[CFG_MSB];
  assign idleCpol = cfgReg[CFG_CPOL];
  assign sckOut   = (busy ? actCpol : cfgReg[CFG_CPOL]) ^ phaseBit;

endmodule

// File: rtl/spi_host_dp.sv
module spi_host_dp
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              orderMsb,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxByte
);

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;
  logic              msbFirst;

  always_comb begin
    rxNext = msbFirst ? {rxShift[DATA_W-2:0], miso}
                      : {miso, rxShift[DATA_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      rxByte   <= '0;
      msbFirst <= 1'b0;
    end else begin
      if (strobe.load) begin
        txShift  <= wrData;
        msbFirst <= orderMsb;
        rxShift  <= '0;
      end else begin
        if (strobe.launch)
          txShift <= msbFirst ? (txShift << 1) : (txShift >> 1);
        if (strobe.capture)
          rxShift <= rxNext;
        if (strobe.finish)
          rxByte <= strobe.capture ? rxNext : rxShift;
      end
    end
  end

  assign mosi = msbFirst ? txShift[DATA_W-1] : txShift[0];

endmodule

// File: rtl/spi_host_port.sv
module spi_host_port
  import spi_host_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EXP_OFFSET = 16,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] rxByte;
  logic              orderMsb;
  logic              busy;
  logic              doneFlag;
  logic              idleCpol;

  spi_host_ctrl #(
    .DATA_W(DATA_W), .EXP_OFFSET(EXP_OFFSET), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .rxByte(rxByte), .regRdData(regRdData),
    .strobe(strobe), .orderMsb(orderMsb), .sckOut(sck), .busy(busy),
    .doneFlag(doneFlag), .idleCpol(idleCpol)
  );

  spi_host_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .orderMsb(orderMsb), .miso(miso), .mosi(mosi), .rxByte(rxByte)
  );

endmodule

// File: rtl/spi_host_port_chk.sv
module spi_host_port_chk
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regAddr,
  input logic       regWrEn,
  input logic       wrDoneBit,
  input logic       rdBit7,
  input logic       rdBit5,
  input logic       sck,
  input logic       busy,
  input logic       doneFlag,
  input logic       idleCpol
);

  localparam int EDGE_CNT = 2 * DATA_W;
  localparam int TC_W     = $clog2(EDGE_CNT) + 1;

  logic [TC_W-1:0] toggleCnt;
  logic            sckQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toggleCnt <= '0;
      sckQ      <= 1'b0;
    end else begin
      sckQ <= sck;
      if (!busy)            toggleCnt <= '0;
      else if (sck != sckQ) toggleCnt <= toggleCnt + 1'b1;
    end
  end

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn && (regAddr == ADDR_DATA)));

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (sck == idleCpol));

  // R3
  sck_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ((toggleCnt == TC_W'(EDGE_CNT - 1)) && (sck != sckQ)));

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $fell(busy));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !(regWrEn && (regAddr == ADDR_STATUS) && !wrDoneBit)) |=> doneFlag);

  // R9
  stat_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS) |-> (!rdBit7 && !rdBit5));

endmodule

bind spi_host_port spi_host_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .wrDoneBit(regWrData[1]), .rdBit7(regRdData[7]), .rdBit5(regRdData[5]),
  .sck(sck), .busy(busy), .doneFlag(doneFlag), .idleCpol(idleCpol)
);

// File: tb/spi_host_port_tb_top.sv
module spi_host_port_tb_top;
  import spi_host_pkg::*;

  localparam int DW   = 8;
  localparam int EOFF = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sck, mosi;
  logic       miso = 1'b0;

  always #4 clk = ~clk;

  spi_host_port #(.DATA_W(DW), .EXP_OFFSET(EOFF), .CNT_W(16)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  longint cycleNo = 0;

  always @(posedge clk) cycleNo <= cycleNo + 1;

  // reference model state
  logic [7:0] mCfg = 8'h00;
  longint c0 = -1000000;
  longint mH = 1;
  logic mCpol = 1'b0;

  function automatic longint halfOf(input logic [4:0] e);
    if (int'(e) <= EOFF) return 1;
    return longint'(1) << (int'(e) - EOFF);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin : perClk
    longint el;
    longint n;
    logic es;
    logic eb;
    #1;
    if (rstN && !finished) begin
      el = cycleNo - c0;
      eb = (el < 16 * mH);
      if (!eb) es = mCfg[7];
      else begin
        n = el / mH;
        es = mCpol ^ n[0];
      end
      check(sck === es, "R3 sck timeline", longint'(sck), longint'(es));
      if (regAddr == ADDR_STATUS && !regWrEn)
        check(regRdData[0] === eb, "R2 busy window", longint'(regRdData[0]), longint'(eb));
    end
  end

  // bench-side SPI slave
  bit slvOn = 1'b0;
  int slvEdge, slvOutIdx, slvInIdx;
  logic [7:0] slvTx, slvRx;
  logic prevSck = 1'b0;
  logic sCpha, sMsb;
  bit slvLead;

  always @(negedge clk) begin
    #1;
    if (slvOn && (sck !== prevSck)) begin
      slvLead = (slvEdge % 2 == 0);
      if (sCpha ? !slvLead : slvLead) begin
        slvRx[sMsb ? 7 - slvInIdx : slvInIdx] = mosi;
        slvInIdx++;
      end else if (!(sCpha && slvEdge == 0)) begin
        slvOutIdx++;
        if (slvOutIdx < 8) miso = slvTx[sMsb ? 7 - slvOutIdx : slvOutIdx];
      end
      slvEdge++;
      if (slvEdge == 16) slvOn = 1'b0;
    end
    prevSck = sck;
  end

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    bit startIt;
    startIt = (a == ADDR_DATA) && ((cycleNo - c0) >= 16 * mH);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    if (startIt) begin
      c0 = cycleNo; mH = halfOf(mCfg[4:0]); mCpol = mCfg[7];
    end
    if (a == ADDR_CONFIG) mCfg = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #2;
    d = regRdData;
    @(negedge clk);
  endtask

  task automatic runXfer(input logic [7:0] cfg, input logic [7:0] tx,
                         input logic [7:0] sb, input bit intrude, input string tag);
    logic [7:0] rd;
    regWrite(ADDR_STATUS, 8'h00);
    regRead(ADDR_STATUS, rd);
    check(rd[1] === 1'b0, {tag, " R7 done cleared"}, longint'(rd[1]), 0);
    regWrite(ADDR_CONFIG, cfg);
    @(negedge clk);
    slvTx = sb; slvRx = 8'h00; slvEdge = 0; slvOutIdx = 0; slvInIdx = 0;
    sCpha = cfg[6]; sMsb = cfg[5];
    miso = sb[cfg[5] ? 7 : 0];
    slvOn = 1'b1;
    regWrite(ADDR_DATA, tx);
    regAddr = ADDR_STATUS;
    if (intrude) begin
      repeat (10) @(negedge clk);
      regWrite(ADDR_DATA, ~tx); // R8: must be ignored
      regAddr = ADDR_STATUS;
    end
    while ((cycleNo - c0) < 16 * mH + 2) @(negedge clk);
    check(slvRx === tx, {tag, " R4 R5 mosi stream"}, longint'(slvRx), longint'(tx));
    check(slvEdge == 16, {tag, " R3 edge count"}, slvEdge, 16);
    regRead(ADDR_DATA, rd);
    check(rd === sb, {tag, " R6 R4 R5 received byte"}, longint'(rd), longint'(sb));
    regRead(ADDR_STATUS, rd);
    check(rd[1] === 1'b1, {tag, " R7 done set"}, longint'(rd[1]), 1);
  endtask

  initial begin : mainSeq
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(ADDR_STATUS, rd); check(rd === 8'h00, "R1 status reset", longint'(rd), 0);
    regRead(ADDR_CONFIG, rd); check(rd === 8'h00, "R1 config reset", longint'(rd), 0);
    regRead(ADDR_DATA, rd);   check(rd === 8'h00, "R1 data reset", longint'(rd), 0);
    check(sck === 1'b0, "R1 sck reset", longint'(sck), 0);
    check(mosi === 1'b0, "R1 mosi reset", longint'(mosi), 0);

    // mode variants; cfg = {cpol[7], cpha[6], msb[5], exp[4:0]}
    runXfer(8'h20, 8'hA5, 8'h3C, 1'b0, "mode0 msb E0");
    runXfer(8'hD1, 8'hF0, 8'h96, 1'b0, "cpol1 cpha1 lsb E17");
    runXfer(8'hB2, 8'h5A, 8'hC3, 1'b0, "cpol1 cpha0 msb E18");
    runXfer(8'h50, 8'h01, 8'h80, 1'b0, "cpha1 lsb E16");
    runXfer(8'h14, 8'h6D, 8'hB7, 1'b0, "mode0 lsb E20");
    runXfer(8'h03, 8'hFF, 8'h00, 1'b0, "mode0 lsb E3");

    // R7 sticky done
    regWrite(ADDR_STATUS, 8'h02);
    repeat (3) @(negedge clk);
    regRead(ADDR_STATUS, rd);
    check(rd[1] === 1'b1, "R7 write 1 keeps done", longint'(rd[1]), 1);
    regWrite(ADDR_STATUS, 8'h00);
    regRead(ADDR_STATUS, rd);
    check(rd[1] === 1'b0, "R7 write 0 clears done", longint'(rd[1]), 0);

    // R9 fixed mode bits
    regWrite(ADDR_STATUS, 8'hFF);
    regRead(ADDR_STATUS, rd);
    check((rd & 8'hA0) === 8'h00, "R9 mode bits read 0", longint'(rd), 0);
    runXfer(8'h60, 8'hC9, 8'h1E, 1'b0, "R9 still master");

    // R8 write while busy
    runXfer(8'h32, 8'h81, 8'h5B, 1'b1, "R8 busy write");
    regRead(ADDR_DATA, rd);
    check(rd === 8'h5B, "R8 data unaffected", longint'(rd), longint'(8'h5B));

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule